// File: doc/BRIEF.md
# Transport-Triggered Move Sequencer

This block is the bus master of a transport-triggered datapath. That datapath has one operation: a move from a source socket to a destination socket. The block fetches one 16-bit move word at a time from instruction storage through a valid/ready style request. It drives the word onto the socket address bus and raises the address strobe one cycle later. It then follows the three-strobe handshake:

- The source unit answers with a data strobe once it has put its value on the data bus.
- The destination unit answers with an acknowledge strobe once it has taken that value.
- When the acknowledge rising edge arrives, the program counter moves on by one.

A unit that supplies its value straight from the address bits may acknowledge without ever raising a data strobe. That short form is accepted. A phase that receives no rising edge within a set number of clocks is a bus error: the block flags which side failed, halts, and keeps the faulting move word on the address bus until a clear input releases it. A run input lets moves execute back to back. A step pulse executes exactly one move while run is low.

All strobes are sampled on the system clock. A rising edge is a sample at one that follows a sample at zero.

Top module: `tta_move_master`

## Requirements
- R1: The move word is captured as received on the fetch interface and driven on `bus_addr`. Its upper byte `[15:8]` is the source socket and its lower byte `[7:0]` is the destination socket. The value holds until the next fetch completes.
- R2: The address strobe rises in the cycle after the new move word appears on `bus_addr`, so the address is stable for at least one full cycle before the strobe edge.
- R3: While the strobe is high, a data strobe rising edge starts the acknowledge phase. An acknowledge rising edge in that phase ends the move: the address strobe falls and `fetch_addr` increments by one.
- R4: An acknowledge rising edge seen during the data phase, with no data strobe before it, also completes the move. When both edges appear in the same sample, the acknowledge wins.
- R5: If no data strobe or acknowledge rising edge is sampled in the first TIMEOUT cycles of the data phase, `src_err` sets and `halted` rises. An edge in the last of those cycles is still accepted.
- R6: If no acknowledge rising edge is sampled in the first TIMEOUT cycles after the data strobe edge, `dst_err` sets and `halted` rises. An edge in the last of those cycles is still accepted.
- R7: While halted, the block keeps the faulting word on `bus_addr`, keeps the address strobe high, requests no fetch and keeps the program counter. A `clear` pulse drops both error flags and `halted`, and the same move is fetched again.
- R8: With `run` low the block stays idle and issues no fetch. A one-cycle `step` pulse makes it execute exactly one move and then return to idle.
- R9: `fetch_req` stays high with a stable `fetch_addr` until `fetch_valid` is sampled high. That sample captures `fetch_instr`.
- R10: After reset, `fetch_req`, `addr_strobe`, `src_err`, `dst_err` and `halted` are low, and `fetch_addr` and `bus_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute moves continuously |
| step | input | 1 | One-cycle pulse to execute a single move while idle |
| clear | input | 1 | Release the halt state and drop the error flags |
| fetch_req | output | 1 | Request for the move word at `fetch_addr` |
| fetch_addr | output | PC_W | Program counter |
| fetch_valid | input | 1 | Move word on `fetch_instr` is valid |
| fetch_instr | input | 16 | Fetched move word: source byte high, destination byte low |
| bus_addr | output | 16 | Socket address bus |
| addr_strobe | output | 1 | Address strobe |
| data_strobe | input | 1 | Data strobe from the source unit |
| ack_strobe | input | 1 | Acknowledge strobe from the destination unit |
| src_err | output | 1 | No data strobe arrived in time |
| dst_err | output | 1 | No acknowledge arrived in time |
| halted | output | 1 | Execution stopped on a bus error |

## Verification
The bench builds the block with TIMEOUT = 6 and PC_W = 5. With the short timeout, strobe edges can be placed exactly on the last accepted cycle and on the first late cycle of both phases within a few clocks. The function-unit model picks its timing from the source byte of each move. One program therefore covers normal moves, acknowledge-only moves, simultaneous edges, and every boundary and error case. The small counter width keeps program-counter values easy to compare against the behavioural reference.

// File: rtl/tta_move_master.sv
module tta_move_master #(
  parameter int PC_W    = 8,
  parameter int TIMEOUT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            step,
  input  logic            clear,
  output logic            fetch_req,
  output logic [PC_W-1:0] fetch_addr,
  input  logic            fetch_valid,
  input  logic [15:0]     fetch_instr,
  output logic [15:0]     bus_addr,
  output logic            addr_strobe,
  input  logic            data_strobe,
  input  logic            ack_strobe,
  output logic            src_err,
  output logic            dst_err,
  output logic            halted
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ADDR, S_DATA, S_ACK, S_DONE, S_HALT
  } st_t;

  st_t            state, nxt;
  logic [CW-1:0]  cnt;
  logic [PC_W-1:0] pc;
  logic [15:0]    word;
  logic           ds_q, ak_q;

  wire ds_rise = data_strobe & ~ds_q;
  wire ak_rise = ack_strobe & ~ak_q;
  wire expired = (cnt == LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (run || step) nxt = S_FETCH;
      S_FETCH: if (fetch_valid) nxt = S_ADDR;
      S_ADDR:  nxt = S_DATA;
      S_DATA: begin
        if (ak_rise)      nxt = S_DONE;
        else if (ds_rise) nxt = S_ACK;
        else if (expired) nxt = S_HALT;
      end
      S_ACK: begin
        if (ak_rise)      nxt = S_DONE;
        else if (expired) nxt = S_HALT;
      end
      S_DONE:  nxt = S_IDLE;
      S_HALT:  if (clear) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      pc      <= '0;
      word    <= '0;
      ds_q    <= 1'b0;
      ak_q    <= 1'b0;
      src_err <= 1'b0;
      dst_err <= 1'b0;
    end else begin
      state <= nxt;
      ds_q  <= data_strobe;
      ak_q  <= ack_strobe;
      if (nxt != state)
        cnt <= '0;
      else if (state == S_DATA || state == S_ACK)
        cnt <= cnt + 1'b1;
      if (state == S_FETCH && fetch_valid)
        word <= fetch_instr;
      if (state == S_DONE)
        pc <= pc + 1'b1;
      if (state == S_DATA && nxt == S_HALT)
        src_err <= 1'b1;
      if (state == S_ACK && nxt == S_HALT)
        dst_err <= 1'b1;
      if (state == S_HALT && clear) begin
        src_err <= 1'b0;
        dst_err <= 1'b0;
      end
    end
  end

  assign fetch_req   = (state == S_FETCH);
  assign fetch_addr  = pc;
  assign bus_addr    = word;
  assign addr_strobe = (state == S_DATA) || (state == S_ACK) || (state == S_HALT);
  assign halted      = (state == S_HALT);

  AST_ERR_MEANS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err || dst_err) |-> halted); // R5
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_err && dst_err)); // R6
  AST_HALT_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clear) |=> (halted && addr_strobe && $stable(bus_addr) && $stable(fetch_addr))); // R7
  AST_ADDR_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_strobe) |-> $stable(bus_addr)); // R2
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_valid) |=> (fetch_req && $stable(fetch_addr))); // R9
  AST_PC_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr != $past(fetch_addr)) |-> (fetch_addr == $past(fetch_addr) + 1'b1)); // R3
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
endmodule

// File: tb/tb_tta_move_master.sv
module tb_tta_move_master;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;
  localparam int PW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, step = 1'b0, clear = 1'b0;
  logic fetch_req, fetch_valid = 1'b0;
  logic [PW-1:0] fetch_addr;
  logic [15:0] fetch_instr = '0, bus_addr;
  logic addr_strobe, data_strobe = 1'b0, ack_strobe = 1'b0;
  logic src_err, dst_err, halted;

  int tests = 0, fails = 0;
  logic [15:0] imem [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  tta_move_master #(.PC_W(PW), .TIMEOUT(T)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .clear(clear),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
    .fetch_instr(fetch_instr), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
    .data_strobe(data_strobe), .ack_strobe(ack_strobe),
    .src_err(src_err), .dst_err(dst_err), .halted(halted));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle,1 fetch,2 addr,3 data,4 ack,5 done,6 halt
  int ph = 0, tm = 0, m_pc = 0;
  logic [15:0] m_word = '0;
  bit m_se = 0, m_de = 0, pds = 0, pak = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; tm = 0; m_pc = 0; m_word = '0; m_se = 0; m_de = 0; pds = 0; pak = 0;
    end else begin
      bit dr, ar;
      dr = data_strobe && !pds;
      ar = ack_strobe && !pak;
      pds = data_strobe;
      pak = ack_strobe;
      case (ph)
        0: if (run || step) ph = 1;
        1: if (fetch_valid) begin m_word = fetch_instr; ph = 2; end
        2: begin ph = 3; tm = 0; end
        3: if (ar) ph = 5;
           else if (dr) begin ph = 4; tm = 0; end
           else if (tm == T-1) begin ph = 6; m_se = 1; end
           else tm++;
        4: if (ar) ph = 5;
           else if (tm == T-1) begin ph = 6; m_de = 1; end
           else tm++;
        5: begin m_pc = (m_pc + 1) % 32; ph = 0; end
        default: if (clear) begin ph = 0; m_se = 0; m_de = 0; end
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(fetch_req === (ph == 1), "R9 fetch_req vs model", fetch_req, ph == 1);
    chk(fetch_addr === PW'(m_pc), "R3 fetch_addr vs model", fetch_addr, m_pc);
    chk(bus_addr === m_word, "R1 bus_addr vs model", bus_addr, m_word);
    chk(addr_strobe === (ph >= 3 && ph != 5), "R2 addr_strobe vs model", addr_strobe, ph >= 3 && ph != 5);
    chk(src_err === m_se, "R5 src_err vs model", src_err, m_se);
    chk(dst_err === m_de, "R6 dst_err vs model", dst_err, m_de);
    chk(halted === (ph == 6), "R7 halted vs model", halted, ph == 6);
  end

  // function-unit and memory models, timing chosen by source byte
  int rn = 0;
  always @(negedge clk) begin
    int dsd, akd;
    #1;
    fetch_valid = fetch_req;
    fetch_instr = imem[fetch_addr];
    case (bus_addr[15:8])
      8'h20: begin dsd = -1;  akd = 2;       end
      8'h30: begin dsd = -1;  akd = -1;      end
      8'h40: begin dsd = 1;   akd = -1;      end
      8'h50: begin dsd = T-1; akd = 2*T-1;   end
      8'h60: begin dsd = T;   akd = -1;      end
      8'h70: begin dsd = 1;   akd = T+1;     end
      8'h80: begin dsd = 1;   akd = T+2;     end
      8'h90: begin dsd = 2;   akd = 2;       end
      default: begin dsd = 1; akd = 3;       end
    endcase
    if (!addr_strobe) begin
      rn = 0; data_strobe = 0; ack_strobe = 0;
    end else begin
      data_strobe = (dsd >= 0 && rn >= dsd);
      ack_strobe  = (rn == akd);
      rn++;
    end
  end

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_clear();
    @(negedge clk); #2 clear = 1;
    @(negedge clk); #2 clear = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) imem[i] = 16'h1000 | 16'(i);
    imem[0] = 16'h1005; imem[1] = 16'h2033; imem[2] = 16'h5011;
    imem[3] = 16'h7022; imem[4] = 16'h9044; imem[5] = 16'h3055;
    repeat (3) @(negedge clk);
    chk(fetch_req == 0 && addr_strobe == 0 && halted == 0 && src_err == 0 && dst_err == 0,
        "R10 reset outputs", {fetch_req, addr_strobe, halted, src_err, dst_err}, 0);
    chk(fetch_addr == 0 && bus_addr == 0, "R10 reset counters", {fetch_addr, bus_addr}, 0);
    #2 rst_n = 1;
    repeat (4) @(negedge clk);
    chk(fetch_req == 0, "R8 idle without run", fetch_req, 0);
    #2 run = 1;
    wait_halt();
    chk(fetch_addr == 5, "R4 R3 five moves done incl ack-only and boundary", fetch_addr, 5);
    chk(src_err == 1 && dst_err == 0, "R5 missing data strobe", {src_err, dst_err}, 2'b10);
    chk(bus_addr[15:8] == 8'h30 && bus_addr[7:0] == 8'h55, "R1 faulting word bytes", bus_addr, 16'h3055);
    repeat (5) @(negedge clk);
    chk(halted && addr_strobe && !fetch_req && bus_addr == 16'h3055, "R7 halt holds bus",
        {halted, addr_strobe, fetch_req}, 3'b110);
    imem[5] = 16'h4066;
    pulse_clear();
    wait_halt();
    chk(dst_err == 1 && src_err == 0 && bus_addr == 16'h4066, "R6 missing acknowledge",
        {src_err, dst_err}, 2'b01);
    imem[5] = 16'h6077;
    pulse_clear();
    wait_halt();
    chk(src_err == 1 && fetch_addr == 5, "R5 data strobe one cycle late", src_err, 1);
    imem[5] = 16'h8088;
    pulse_clear();
    wait_halt();
    chk(dst_err == 1 && fetch_addr == 5, "R6 acknowledge one cycle late", dst_err, 1);
    #2 run = 0;
    imem[5] = 16'h1099;
    pulse_clear();
    repeat (4) @(negedge clk);
    chk(!halted && !src_err && !dst_err && !fetch_req, "R7 clear releases, R8 stays idle",
        {halted, src_err, dst_err, fetch_req}, 0);
    #2 step = 1;
    @(negedge clk); #2 step = 0;
    repeat (20) @(negedge clk);
    chk(fetch_addr == 6 && !fetch_req && !addr_strobe && bus_addr == 16'h1099,
        "R8 single step executes one move", fetch_addr, 6);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule